// File: doc/BRIEF.md
# Dual-Channel Serial Port Register Front End

This block is the register file and interrupt logic that a host sees for a two-channel serial port. Channel 0 is the console channel and channel 1 the auxiliary channel. Each channel has three registers: a status register, a command register that takes writes and discards them, and a one-byte holding register. A read of the holding register removes the received byte, and a write sends a byte out. A shared register holds the interrupt enables, and one interrupt request line serves both channels. Baud-rate generation, serialization and framing belong to a neighbouring block. That block hands this one received bytes through a data bus and a valid strobe, and takes transmit bytes through the same kind of pair.

The host bus is synchronous. A read strobe latches the selected register into `bus_rdata` on the clock edge, and the value holds until the next read. A write strobe acts on the same edge. The transmitter is treated as always able to accept a byte. A periodic `tick` input lets software that enabled a transmit-ready interrupt see the interrupt line again.

Top module: `dual_uart_regs`

## Requirements
- R1: After reset, `irq` and both `tx_valid` bits are 0, both holding registers are empty, the enable register reads 0x00, and `bus_rdata` is 0x00.
- R2: A read of a channel's status register (channel 0 at 0x40C, channel 1 at 0x44C) returns bit 0 = 1 when a received byte is waiting, bit 2 = 1 always, and 0 in every other bit.
- R3: A read of a channel's holding register (0x41C, 0x45C) returns the waiting byte and leaves the register empty. A read of an empty holding register returns 0x00.
- R4: A byte that arrives while the holding register is full replaces the old byte.
- R5: A write to a holding register pulses that channel's `tx_valid` high for exactly the next cycle, with `tx_data` equal to the low 8 bits written.
- R6: A write to the enable register at 0x42C stores the 8-bit value, and a read returns it. Bit 0 enables transmit-ready on channel 0, bit 1 enables receive-ready on channel 0, bit 4 enables transmit-ready on channel 1, and bit 5 enables receive-ready on channel 1.
- R7: A byte arriving on a channel whose receive-ready enable is set raises `irq` in the next cycle. A byte arriving with that enable clear leaves `irq` unchanged.
- R8: A `tick` pulse raises `irq` in the next cycle when bit 0 or bit 4 of the enable register is set.
- R9: A read of channel 0's status register drops `irq` in the next cycle. A read of channel 1's status register leaves `irq` unchanged.
- R10: When a raise cause and a channel 0 status read fall in the same cycle, `irq` is 1 afterwards. When a byte arrives in the same cycle as a holding read, the read returns the old contents and the new byte stays waiting.
- R11: Writes to the command registers (0x414, 0x454) change nothing. Reads of command registers and of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held until the next read |
| tick | input | 1 | Periodic transmit-ready reminder pulse |
| rx_data | input | 16 | Received bytes, channel 1 in [15:8], channel 0 in [7:0] |
| rx_valid | input | 2 | Received-byte strobes, one per channel |
| tx_data | output | 16 | Transmit bytes, channel 1 in [15:8], channel 0 in [7:0] |
| tx_valid | output | 2 | One-cycle transmit strobes, one per channel |
| irq | output | 1 | Shared interrupt request |

## Verification
Two pairs of events can fall in the same cycle. A raise cause (a byte arrival or a tick) can meet a clear from a channel 0 status read. A byte arrival can meet a holding-register read on the same channel. Directed steps drive each pair on one edge. The bench then expects `irq` to stay high, expects the read to return the old byte, and expects a status read to show the new byte still waiting. The random phase fires strobes, ticks and bus operations independently on every cycle, so both collisions also occur many times. Each result is judged against a cycle-level bench model.

// File: rtl/duart_fe_pkg.sv
package duart_fe_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int NUM_CH = 2;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    // Channel 0 offsets; each further channel sits one stride higher
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_HOLD  = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h42C;
    localparam logic [ADDR_W-1:0] CH_STRIDE = 12'h040;

    localparam int ST_RX_BIT = 0;
    localparam int ST_TX_BIT = 2;

    typedef enum logic [2:0] {SEL_NONE, SEL_STAT, SEL_CMD, SEL_HOLD, SEL_MASK} sel_e;

    typedef struct packed {
        sel_e            sel;
        logic [CH_W-1:0] ch;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = SEL_NONE;
        d.ch  = '0;
        if (a == OFS_MASK) d.sel = SEL_MASK;
        for (int c = 0; c < NUM_CH; c++) begin
            logic [ADDR_W-1:0] off;
            off = ADDR_W'(c) * CH_STRIDE;
            if (a == OFS_STAT + off) begin d.sel = SEL_STAT; d.ch = CH_W'(c); end
            if (a == OFS_CMD  + off) begin d.sel = SEL_CMD;  d.ch = CH_W'(c); end
            if (a == OFS_HOLD + off) begin d.sel = SEL_HOLD; d.ch = CH_W'(c); end
        end
        return d;
    endfunction

    // Enable-register bit positions per channel
    function automatic int tx_en_bit(input int c);
        return 4 * c;
    endfunction

    function automatic int rx_en_bit(input int c);
        return 4 * c + 1;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic waiting);
        logic [DATA_W-1:0] s;
        s = '0;
        s[ST_RX_BIT] = waiting;
        s[ST_TX_BIT] = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/uart_fe_chan.sv
module uart_fe_chan
    import duart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic              push_tx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              full,
    output logic [DATA_W-1:0] held,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else begin
            if (pop) full <= 1'b0;
            if (rx_valid) begin
                full <= 1'b1;
                held <= rx_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= push_tx;
            if (push_tx) tx_data <= wdata;
        end
    end

    // R5
    tx_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(push_tx));

    // R4
    rx_fills_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> full);

    // R3
    pop_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !rx_valid) |=> !full);
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq
    import duart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] rx_valid,
    input  logic              tick,
    input  logic              clr,
    output logic [DATA_W-1:0] mask,
    output logic              irq
);
    logic set;

    always_comb begin
        set = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            set = set | (rx_valid[c] & mask[rx_en_bit(c)])
                      | (tick & mask[tx_en_bit(c)]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            if (mask_we) mask <= wdata;
            if (set)      irq <= 1'b1;
            else if (clr) irq <= 1'b0;
        end
    end

    // R9
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !(|rx_valid) && !tick) |=> !irq);

    // R7
    raise_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((|rx_valid) || tick));

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && set) |=> irq);
endmodule

// File: rtl/dual_uart_regs.sv
module dual_uart_regs
    import duart_fe_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     tick,
    input  logic [NUM_CH*DATA_W-1:0] rx_data,
    input  logic [NUM_CH-1:0]        rx_valid,
    output logic [NUM_CH*DATA_W-1:0] tx_data,
    output logic [NUM_CH-1:0]        tx_valid,
    output logic                     irq
);
    dec_t              dec;
    logic [NUM_CH-1:0] full;
    logic [DATA_W-1:0] held [NUM_CH];
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] rmux;
    logic              clr_irq;

    assign dec     = decode(bus_addr);
    assign clr_irq = bus_rd && (dec.sel == SEL_STAT) && (dec.ch == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = (dec.sel == SEL_HOLD) && (dec.ch == CH_W'(c));
        uart_fe_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .pop      (bus_rd && hit),
            .push_tx  (bus_wr && hit),
            .wdata    (bus_wdata),
            .rx_data  (rx_data[c*DATA_W +: DATA_W]),
            .rx_valid (rx_valid[c]),
            .full     (full[c]),
            .held     (held[c]),
            .tx_data  (tx_data[c*DATA_W +: DATA_W]),
            .tx_valid (tx_valid[c])
        );
    end

    uart_fe_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .mask_we  (bus_wr && (dec.sel == SEL_MASK)),
        .wdata    (bus_wdata),
        .rx_valid (rx_valid),
        .tick     (tick),
        .clr      (clr_irq),
        .mask     (mask),
        .irq      (irq)
    );

    always_comb begin
        case (dec.sel)
            SEL_STAT: rmux = status_word(full[dec.ch]);
            SEL_HOLD: rmux = full[dec.ch] ? held[dec.ch] : '0;
            SEL_MASK: rmux = mask;
            default:  rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rmux;
    end

    // R2
    status_tx_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.sel == SEL_STAT) |=> bus_rdata[ST_TX_BIT]);

    // R11
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (dec.sel == SEL_CMD || dec.sel == SEL_NONE)) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_dual_uart_regs.sv
module tb_dual_uart_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tick = 1'b0;
    logic [15:0] rx_data = '0;
    logic [1:0]  rx_valid = '0;
    logic [15:0] tx_data;
    logic [1:0]  tx_valid;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    bit       m_full [2];
    bit [7:0] m_byte [2];
    bit [7:0] m_mask;
    bit       m_irq;
    bit [7:0] m_rdata;

    always #2 clk = ~clk;

    dual_uart_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .rx_data(rx_data),
        .rx_valid(rx_valid), .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_read(input bit [11:0] a);
        case (a)
            12'h40C: return 8'h04 | 8'(m_full[0]);
            12'h44C: return 8'h04 | 8'(m_full[1]);
            12'h41C: return m_full[0] ? m_byte[0] : 8'h00;
            12'h45C: return m_full[1] ? m_byte[1] : 8'h00;
            12'h42C: return m_mask;
            default: return 8'h00;
        endcase
    endfunction

    // One clock of stimulus, model update and comparison (called at negedge)
    task automatic step(input string tag, input bit rd, input bit wr, input bit [11:0] a,
                        input bit [7:0] wd, input bit [1:0] rxv, input bit [15:0] rxd,
                        input bit tk);
        bit set, clr;
        bit [1:0]  etxv;
        bit [15:0] etxd;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        rx_valid = rxv; rx_data = rxd; tick = tk;
        if (rd) m_rdata = exp_read(a);
        set = (rxv[0] & m_mask[1]) | (rxv[1] & m_mask[5]) | (tk & (m_mask[0] | m_mask[4]));
        clr = rd && (a == 12'h40C);
        if (set) m_irq = 1; else if (clr) m_irq = 0;
        if (rd && a == 12'h41C) m_full[0] = 0;
        if (rd && a == 12'h45C) m_full[1] = 0;
        for (int c = 0; c < 2; c++)
            if (rxv[c]) begin m_full[c] = 1; m_byte[c] = rxd[c*8 +: 8]; end
        if (wr && a == 12'h42C) m_mask = wd;
        etxv = {wr && a == 12'h45C, wr && a == 12'h41C};
        etxd = tx_data;
        if (etxv[0]) etxd[7:0] = wd;
        if (etxv[1]) etxd[15:8] = wd;
        @(posedge clk);
        @(negedge clk);
        check({tag, " rdata"}, bus_rdata, m_rdata);
        check("R7,R8,R9 irq", irq, m_irq);
        check("R5 tx_valid", tx_valid, etxv);
        if (|etxv) check("R5 tx_data", tx_data, etxd);
        bus_rd = 0; bus_wr = 0; rx_valid = 0; tick = 0;
    endtask

    task automatic idle();
        step("idle", 0, 0, 12'h000, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [11:0] addrs [8];
        int unused;
        addrs = '{12'h40C, 12'h414, 12'h41C, 12'h42C, 12'h44C, 12'h454, 12'h45C, 12'h400};
        unused = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 rdata", bus_rdata, 0);
        step("R1 mask", 1, 0, 12'h42C, 0, 0, 0, 0);
        step("R1 holdA empty", 1, 0, 12'h41C, 0, 0, 0, 0);
        // R6 enable register
        step("R6 write", 0, 1, 12'h42C, 8'h02, 0, 0, 0);
        step("R6 readback", 1, 0, 12'h42C, 0, 0, 0, 0);
        // R7 arrival with enable; R2 status
        step("R7 arrive A", 0, 0, 0, 0, 2'b01, 16'h00A5, 0);
        step("R2 statB empty", 1, 0, 12'h44C, 0, 0, 0, 0);
        step("R9 statA clears", 1, 0, 12'h40C, 0, 0, 0, 0);
        // R4 overwrite, R3 pop then empty
        step("R4 arrive again", 0, 0, 0, 0, 2'b01, 16'h003C, 0);
        step("R3 holdA", 1, 0, 12'h41C, 0, 0, 0, 0);
        step("R3 holdA empty", 1, 0, 12'h41C, 0, 0, 0, 0);
        // R7 arrival on B without enable
        step("R7 B no enable", 0, 0, 0, 0, 2'b10, 16'h7E00, 0);
        // R8 tick with channel 1 transmit enable; R9 status B keeps irq
        step("R8 mask", 0, 1, 12'h42C, 8'h10, 0, 0, 0);
        step("R8 tick", 0, 0, 0, 0, 0, 0, 1);
        step("R9 statB keeps", 1, 0, 12'h44C, 0, 0, 0, 0);
        // R10 raise beats clear
        step("R10 tick+clear", 1, 0, 12'h40C, 0, 0, 0, 1);
        step("R9 clear", 1, 0, 12'h40C, 0, 0, 0, 0);
        // R10 arrival during pop
        step("R10 pop+arrive", 1, 0, 12'h45C, 0, 2'b10, 16'h9900, 0);
        step("R10 still waiting", 1, 0, 12'h44C, 0, 0, 0, 0);
        step("R10 new byte", 1, 0, 12'h45C, 0, 0, 0, 0);
        // R11 command writes ignored, reads zero
        step("R11 cmd write", 0, 1, 12'h414, 8'hFF, 0, 0, 0);
        step("R11 cmdB write", 0, 1, 12'h454, 8'hFF, 0, 0, 0);
        step("R11 mask kept", 1, 0, 12'h42C, 0, 0, 0, 0);
        step("R11 cmd read", 1, 0, 12'h414, 0, 0, 0, 0);
        step("R11 unmapped", 1, 0, 12'h400, 0, 0, 0, 0);
        // R5 transmit on both channels
        step("R5 txA", 0, 1, 12'h41C, 8'h5A, 0, 0, 0);
        idle();
        step("R5 txB", 0, 1, 12'h45C, 8'hC3, 0, 0, 0);
        idle();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit [11:0] a;
            bit op_rd, op_wr;
            a = addrs[$urandom_range(7, 0)];
            op_rd = ($urandom_range(2, 0) == 0);
            op_wr = ($urandom_range(2, 0) == 0);
            step("R2,R3,R6,R11 random", op_rd, op_wr, a, 8'($urandom),
                 2'($urandom_range(3, 0) & (($urandom_range(3, 0) == 0) ? 3 : 0)),
                 16'($urandom), ($urandom_range(15, 0) == 0));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule